// File: doc/BRIEF.md
# ADC Range Control Gain Loop

This block keeps the magnitude of the converter output inside a programmed band. It does so by steering an attenuator control register. Two paths act on that register.

The slow path adds up sample magnitudes while an external sequencer holds the integration window open. After a programmable power-of-two count of samples it compares the average against a lower and an upper threshold:

- Above the upper threshold, it adds an attack step.
- Below the lower threshold, it subtracts a decay step.
- Inside the band, it subtracts a small bias step. This gives back attenuation that is no longer needed.

The fast path compares every single sample against an immediate threshold. On an exceedance it adds its own step at once. It then stays deaf for a programmable number of cycles while the change works its way back to the converter.

The register is wider than the three bits that drive the analog gain. The lower bits let steps be finer than one 6 dB increment, which filters the loop. Only the three top bits leave the block as the coarse gain code, weighted 6, 12 and 24 dB. The timing sequencer, the mapping of the code onto pins and the attenuator itself sit outside.

Top module: `adc_range_ctrl`

## Requirements
- R1: While reset is active, and for the cycles of its synchronous release, `att_reg` and `gain_msb` read zero.
- R2: `gain_msb` always equals the top three bits of `att_reg`. Bit 0 is the 6 dB weight, bit 1 the 12 dB weight and bit 2 the 24 dB weight.
- R3: The magnitude of a sample is the absolute value of its two's-complement code. The most negative code gives the full-scale magnitude 2^(SAMPLE_W-1).
- R4: The slow path works as follows.
  - While `integ_en` is high, every valid sample's magnitude is added to an accumulator.
  - The 2^N-th valid sample closes an average and clears the accumulator. N is `cfg_avg_shift`, clamped to MAX_SHIFT.
  - The average is the sum shifted right by N.
  - A cycle with `integ_en` low discards a partial sum.
- R5: An average strictly above `cfg_upper` raises `att_reg` by `cfg_attack` at the next clock edge.
- R6: An average strictly below `cfg_lower` lowers `att_reg` by `cfg_decay` at the next clock edge.
- R7: An average from `cfg_lower` to `cfg_upper` inclusive lowers `att_reg` by `cfg_bias` at the next clock edge.
- R8: A valid sample whose magnitude is strictly above `cfg_immed` raises `att_reg` by `cfg_imm_step` at the next edge. This does not depend on `integ_en`, provided no hold-off is running.
- R9: After an immediate trigger in cycle t, the immediate threshold is ignored in cycles t+1 to t+`cfg_holdoff`. It can fire again from cycle t+`cfg_holdoff`+1.
- R10: `att_reg` saturates at all ones and at zero. It never wraps.
- R11: When an immediate trigger and an average decision fall in the same cycle, the immediate step is applied and saturated first. The average decision then acts on that result and is saturated in turn.
- R12: In a cycle with neither an immediate trigger nor a closing average, `att_reg` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | A sample is present this cycle |
| smp | input | SAMPLE_W | Two's-complement converter sample |
| integ_en | input | 1 | Integration window from the timing sequencer |
| cfg_avg_shift | input | SHIFT_W | log2 of the samples per average |
| cfg_upper | input | SAMPLE_W | Upper average threshold |
| cfg_lower | input | SAMPLE_W | Lower average threshold |
| cfg_immed | input | SAMPLE_W | Per-sample immediate threshold |
| cfg_holdoff | input | HOLD_W | Cycles the immediate path stays deaf after a trigger |
| cfg_attack | input | ATT_W | Step added when the average is high |
| cfg_decay | input | ATT_W | Step removed when the average is low |
| cfg_bias | input | ATT_W | Step removed when the average is inside the band |
| cfg_imm_step | input | ATT_W | Step added on an immediate trigger |
| att_reg | output | ATT_W | Attenuator control register |
| gain_msb | output | 3 | Coarse gain code, the top bits of the register |

## Verification
The assertions take as given only one thing about the inputs: `smp_vld` and `integ_en` carry known values once reset has been released. Every property is therefore phrased as a cause and its effect inside the block. A rise needs an immediate trigger or a high average. A fall needs a low or in-band average. A quiet cycle keeps the register. A trigger with a non-zero hold-off cannot be followed by another.

The stimulus keeps the thresholds ordered, with lower not above upper, and moves the immediate threshold above most of the in-band traffic. Configuration changes only at segment boundaries, so each segment runs with one set of steps. Directed cases add the most negative code, windows broken off by `integ_en`, saturation at both ends and a coincident trigger and decision near the top.

// File: rtl/range_ctrl_pkg.sv
package range_ctrl_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_MID  = 2'd3
  } range_dir_e;
endpackage

// File: rtl/range_mag.sv
module range_mag #(
  parameter int W = 10
) (
  input  logic [W-1:0] smp,
  output logic [W-1:0] mag
);
  // Unsigned result: the most negative code maps to 2^(W-1), which fits in W bits.
  always_comb begin
    if (smp[W-1]) mag = (~smp) + W'(1);
    else          mag = smp;
  end
endmodule

// File: rtl/range_fast_attack.sv
module range_fast_attack #(
  parameter int MAG_W  = 10,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [MAG_W-1:0]  mag,
  input  logic [MAG_W-1:0]  cfg_immed,
  input  logic [HOLD_W-1:0] cfg_holdoff,
  output logic              fire
);
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              armed;

  always_comb begin
    armed = (hold_q == '0);
    fire  = smp_vld && armed && (mag > cfg_immed);
    if (fire)       hold_d = cfg_holdoff;
    else if (armed) hold_d = '0;
    else            hold_d = hold_q - HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end
endmodule

// File: rtl/range_integrator.sv
module range_integrator #(
  parameter int MAG_W     = 10,
  parameter int MAX_SHIFT = 7,
  parameter int SHIFT_W   = 3,
  localparam int ACC_W    = MAG_W + MAX_SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_vld,
  input  logic               integ_en,
  input  logic [MAG_W-1:0]   mag,
  input  logic [SHIFT_W-1:0] cfg_avg_shift,
  output logic               avg_vld,
  output logic [ACC_W-1:0]   avg_val
);
  logic [ACC_W-1:0]     acc_q, acc_d, sum;
  logic [MAX_SHIFT-1:0] cnt_q, cnt_d, last_cnt;
  logic [SHIFT_W-1:0]   shift_eff;
  logic                 take, acc_en;

  always_comb begin
    shift_eff = (int'(cfg_avg_shift) > MAX_SHIFT) ? SHIFT_W'(MAX_SHIFT) : cfg_avg_shift;
    last_cnt  = MAX_SHIFT'((32'd1 << shift_eff) - 32'd1);
    take      = smp_vld && integ_en;
    sum       = acc_q + ACC_W'(mag);
    avg_vld   = take && (cnt_q == last_cnt);
    avg_val   = sum >> shift_eff;
    acc_en    = !integ_en || take;
    if (!integ_en || avg_vld) begin
      acc_d = '0;
      cnt_d = '0;
    end else begin
      acc_d = sum;
      cnt_d = cnt_q + MAX_SHIFT'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/range_att_update.sv
module range_att_update
  import range_ctrl_pkg::*;
#(
  parameter int ATT_W = 8,
  parameter int MAG_W = 10,
  parameter int ACC_W = 17
) (
  input  logic [ATT_W-1:0] att_q,
  input  logic             imm_fire,
  input  logic [ATT_W-1:0] cfg_imm_step,
  input  logic             avg_vld,
  input  logic [ACC_W-1:0] avg_val,
  input  logic [MAG_W-1:0] cfg_upper,
  input  logic [MAG_W-1:0] cfg_lower,
  input  logic [ATT_W-1:0] cfg_attack,
  input  logic [ATT_W-1:0] cfg_decay,
  input  logic [ATT_W-1:0] cfg_bias,
  output logic [ATT_W-1:0] att_d,
  output range_dir_e       dir
);
  function automatic logic [ATT_W-1:0] sat_up(input logic [ATT_W-1:0] a, input logic [ATT_W-1:0] b);
    logic [ATT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[ATT_W] ? '1 : s[ATT_W-1:0];
  endfunction

  function automatic logic [ATT_W-1:0] sat_dn(input logic [ATT_W-1:0] a, input logic [ATT_W-1:0] b);
    return (a < b) ? '0 : (a - b);
  endfunction

  logic [ATT_W-1:0] stage1;

  always_comb begin
    stage1 = imm_fire ? sat_up(att_q, cfg_imm_step) : att_q;
    dir    = DIR_HOLD;
    att_d  = stage1;
    if (avg_vld) begin
      if (avg_val > ACC_W'(cfg_upper)) begin
        dir   = DIR_UP;
        att_d = sat_up(stage1, cfg_attack);
      end else if (avg_val < ACC_W'(cfg_lower)) begin
        dir   = DIR_DOWN;
        att_d = sat_dn(stage1, cfg_decay);
      end else begin
        dir   = DIR_MID;
        att_d = sat_dn(stage1, cfg_bias);
      end
    end
  end
endmodule

// File: rtl/adc_range_ctrl.sv
module adc_range_ctrl
  import range_ctrl_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int ATT_W     = 8,
  parameter int HOLD_W    = 8,
  parameter int MAX_SHIFT = 7,
  localparam int SHIFT_W  = $clog2(MAX_SHIFT + 1),
  localparam int ACC_W    = SAMPLE_W + MAX_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                integ_en,
  input  logic [SHIFT_W-1:0]  cfg_avg_shift,
  input  logic [SAMPLE_W-1:0] cfg_upper,
  input  logic [SAMPLE_W-1:0] cfg_lower,
  input  logic [SAMPLE_W-1:0] cfg_immed,
  input  logic [HOLD_W-1:0]   cfg_holdoff,
  input  logic [ATT_W-1:0]    cfg_attack,
  input  logic [ATT_W-1:0]    cfg_decay,
  input  logic [ATT_W-1:0]    cfg_bias,
  input  logic [ATT_W-1:0]    cfg_imm_step,
  output logic [ATT_W-1:0]    att_reg,
  output logic [2:0]          gain_msb
);
  logic [1:0]          rst_sync_q;
  logic                rst_q_n;
  logic [SAMPLE_W-1:0] mag;
  logic                imm_fire;
  logic                avg_vld;
  logic [ACC_W-1:0]    avg_val;
  logic [ATT_W-1:0]    att_q, att_d;
  logic                att_en;
  range_dir_e          avg_dir;

  // Asynchronous assertion, release two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  range_mag #(.W(SAMPLE_W)) u_mag (.smp(smp), .mag(mag));

  range_fast_attack #(.MAG_W(SAMPLE_W), .HOLD_W(HOLD_W)) u_fast (
    .clk(clk), .rst_n(rst_q_n), .smp_vld(smp_vld), .mag(mag),
    .cfg_immed(cfg_immed), .cfg_holdoff(cfg_holdoff), .fire(imm_fire)
  );

  range_integrator #(.MAG_W(SAMPLE_W), .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_integ (
    .clk(clk), .rst_n(rst_q_n), .smp_vld(smp_vld), .integ_en(integ_en), .mag(mag),
    .cfg_avg_shift(cfg_avg_shift), .avg_vld(avg_vld), .avg_val(avg_val)
  );

  range_att_update #(.ATT_W(ATT_W), .MAG_W(SAMPLE_W), .ACC_W(ACC_W)) u_upd (
    .att_q(att_q), .imm_fire(imm_fire), .cfg_imm_step(cfg_imm_step),
    .avg_vld(avg_vld), .avg_val(avg_val), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
    .cfg_attack(cfg_attack), .cfg_decay(cfg_decay), .cfg_bias(cfg_bias),
    .att_d(att_d), .dir(avg_dir)
  );

  assign att_en = imm_fire || avg_vld;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    att_q <= '0;
    else if (att_en) att_q <= att_d;
  end

  assign att_reg  = att_q;
  assign gain_msb = att_q[ATT_W-1 -: 3];
endmodule

// File: rtl/range_ctrl_chk.sv
module range_ctrl_chk
  import range_ctrl_pkg::*;
#(
  parameter int ATT_W  = 8,
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              imm_fire,
  input logic              avg_vld,
  input range_dir_e        avg_dir,
  input logic [HOLD_W-1:0] cfg_holdoff,
  input logic [ATT_W-1:0]  att_reg,
  input logic [2:0]        gain_msb
);
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_fire && !(avg_vld && avg_dir == DIR_UP)) |=> (att_reg <= $past(att_reg))); // R5
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(avg_vld && (avg_dir == DIR_DOWN || avg_dir == DIR_MID))) |=> (att_reg >= $past(att_reg))); // R6
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ((imm_fire && !avg_vld) || (avg_vld && avg_dir == DIR_UP)) |=> (att_reg >= $past(att_reg))); // R10
  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_fire && avg_vld && avg_dir != DIR_UP) |=> (att_reg <= $past(att_reg))); // R10
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_fire && !avg_vld) |=> $stable(att_reg)); // R12
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_fire && cfg_holdoff != '0) |=> !imm_fire); // R9
  AST_GAIN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(att_reg) |-> $stable(gain_msb)); // R2
endmodule

bind adc_range_ctrl range_ctrl_chk #(.ATT_W(ATT_W), .HOLD_W(HOLD_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .imm_fire(imm_fire), .avg_vld(avg_vld),
  .avg_dir(avg_dir), .cfg_holdoff(cfg_holdoff), .att_reg(att_reg), .gain_msb(gain_msb)
);

// File: tb/tb_adc_range_ctrl.sv
`timescale 1ns/1ps
module tb_adc_range_ctrl;
  localparam int SW = 10;
  localparam int AW = 8;
  localparam int HW = 8;
  localparam int MS = 7;
  localparam int AMAX = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          smp_vld, integ_en;
  logic [SW-1:0] smp, cfg_upper, cfg_lower, cfg_immed;
  logic [2:0]    cfg_avg_shift;
  logic [HW-1:0] cfg_holdoff;
  logic [AW-1:0] cfg_attack, cfg_decay, cfg_bias, cfg_imm_step;
  logic [AW-1:0] att_reg;
  logic [2:0]    gain_msb;

  int n_chk = 0, n_fail = 0;
  int m_att = 0, m_acc = 0, m_cnt = 0, m_hold = 0;

  always #2 clk = ~clk;

  adc_range_ctrl dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .integ_en(integ_en),
    .cfg_avg_shift(cfg_avg_shift), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
    .cfg_immed(cfg_immed), .cfg_holdoff(cfg_holdoff), .cfg_attack(cfg_attack),
    .cfg_decay(cfg_decay), .cfg_bias(cfg_bias), .cfg_imm_step(cfg_imm_step),
    .att_reg(att_reg), .gain_msb(gain_msb)
  );

  function automatic int mag_of(input logic [SW-1:0] s);
    return s[SW-1] ? ((1 << SW) - int'(s)) : int'(s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, predict, wait one edge, compare at the next negedge.
  task automatic step(input logic v, input int sval, input logic ie, input string tag);
    int mg, sh, nh, dec, avg, a, acc, cnt;
    bit imm, clip;
    string t;
    smp_vld = v; smp = SW'(sval); integ_en = ie;
    mg  = mag_of(SW'(sval));
    sh  = (int'(cfg_avg_shift) > MS) ? MS : int'(cfg_avg_shift);
    imm = v && (mg > int'(cfg_immed)) && (m_hold == 0);
    nh  = imm ? int'(cfg_holdoff) : ((m_hold > 0) ? m_hold - 1 : 0);
    dec = 0; acc = m_acc; cnt = m_cnt; clip = 0;
    if (!ie) begin
      acc = 0; cnt = 0;
    end else if (v) begin
      if (m_cnt == (1 << sh) - 1) begin
        avg = (m_acc + mg) >> sh;
        dec = (avg > int'(cfg_upper)) ? 1 : (avg < int'(cfg_lower)) ? 2 : 3;
        acc = 0; cnt = 0;
      end else begin
        acc = m_acc + mg; cnt = m_cnt + 1;
      end
    end
    a = m_att;
    if (imm) begin a = a + int'(cfg_imm_step); if (a > AMAX) begin a = AMAX; clip = 1; end end
    case (dec)
      1: begin a = a + int'(cfg_attack); if (a > AMAX) begin a = AMAX; clip = 1; end end
      2: begin a = a - int'(cfg_decay);  if (a < 0) begin a = 0; clip = 1; end end
      3: begin a = a - int'(cfg_bias);   if (a < 0) begin a = 0; clip = 1; end end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    if (tag != "")               t = tag;
    else if (imm && dec != 0)    t = "R11";
    else if (clip)               t = "R10";
    else if (imm)                t = "R8";
    else if (dec == 1)           t = "R5";
    else if (dec == 2)           t = "R6";
    else if (dec == 3)           t = "R7";
    else                         t = "R12";
    check(int'(att_reg) == a, t, int'(att_reg), a);
    check(int'(gain_msb) == (a >> (AW - 3)), "R2", int'(gain_msb), a >> (AW - 3));
    m_att = a; m_acc = acc; m_cnt = cnt; m_hold = nh;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_vld = 0; smp = '0; integ_en = 0;
    cfg_avg_shift = 0; cfg_upper = 10'd200; cfg_lower = 10'd100; cfg_immed = 10'd511;
    cfg_holdoff = 0; cfg_attack = 0; cfg_decay = 0; cfg_bias = 0; cfg_imm_step = 0;
    repeat (3) @(negedge clk);
    check(att_reg == '0 && gain_msb == '0, "R1", int'(att_reg), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R1");

    // R3: full-scale negative code triggers, largest codes of either sign do not
    cfg_imm_step = 8'd5;
    step(1, 511, 0, "R3");
    step(1, -511, 0, "R3");
    step(1, -512, 0, "R3");
    check(att_reg == 8'd5, "R3", int'(att_reg), 5);

    // R9: hold-off of three cycles under continuous overload
    cfg_immed = 10'd10; cfg_holdoff = 8'd3; cfg_imm_step = 8'd1;
    for (int i = 0; i < 10; i++) step(1, 300, 0, "R9");
    check(att_reg == 8'd8, "R9", int'(att_reg), 8);

    // R4: four-sample average and a window broken off by integ_en
    cfg_immed = 10'd511; cfg_holdoff = 0; cfg_avg_shift = 3'd2;
    cfg_upper = 10'd100; cfg_lower = 10'd90; cfg_attack = 8'd7; cfg_bias = 8'd2;
    step(1, 100, 1, "R4"); step(1, -100, 1, "R4"); step(0, 0, 1, "R4");
    step(1, 100, 1, "R4"); step(1, 104, 1, "R4");
    check(att_reg == 8'd15, "R4", int'(att_reg), 15);
    step(1, 400, 1, "R4"); step(1, 400, 1, "R4"); step(1, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(1, 95, 1, "R4");
    check(att_reg == 8'd13, "R4", int'(att_reg), 13);

    // R10: saturation at both ends
    cfg_avg_shift = 0; cfg_upper = 10'd10; cfg_lower = 10'd5; cfg_attack = 8'd200;
    for (int i = 0; i < 3; i++) step(1, 300, 1, "R10");
    check(att_reg == 8'd255, "R10", int'(att_reg), 255);
    cfg_upper = 10'd600; cfg_lower = 10'd500; cfg_decay = 8'd200;
    for (int i = 0; i < 3; i++) step(1, 300, 1, "R10");
    check(att_reg == 8'd0, "R10", int'(att_reg), 0);

    // R11: immediate step saturates first, then the decay acts on the result
    cfg_immed = 10'd50; cfg_imm_step = 8'd125;
    step(1, 100, 0, "R8"); step(1, 100, 0, "R8");
    cfg_imm_step = 8'd10; cfg_decay = 8'd20; cfg_lower = 10'd300; cfg_upper = 10'd400;
    step(1, 100, 1, "R11");
    check(att_reg == 8'd235, "R11", int'(att_reg), 235);

    // R12: quiet traffic leaves the register alone
    for (int i = 0; i < 6; i++) step(1, 20, 0, "R12");
    check(att_reg == 8'd235, "R12", int'(att_reg), 235);

    // Constrained random segments
    for (int seg = 0; seg < 20; seg++) begin
      int amp;
      logic ie;
      step(0, 0, 0, "");
      cfg_avg_shift = 3'($urandom % 8);
      cfg_lower     = SW'($urandom % 300);
      cfg_upper     = cfg_lower + SW'($urandom % 200);
      cfg_immed     = SW'(300 + $urandom % 212);
      cfg_holdoff   = HW'($urandom % 20);
      cfg_attack    = AW'($urandom % 40);
      cfg_decay     = AW'($urandom % 40);
      cfg_bias      = AW'($urandom % 8);
      cfg_imm_step  = AW'($urandom % 64);
      amp = 1 + int'($urandom % 512);
      ie  = 1'b1;
      for (int c = 0; c < 1500; c++) begin
        int sv;
        if ($urandom % 100 == 0) ie = ~ie;
        sv = int'($urandom % (2 * amp + 1)) - amp;
        if (sv > 511) sv = 511;
        if ($urandom % 200 == 0) sv = -512;
        step(($urandom % 5) != 0, sv, ie, "");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule